// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

This block is one bank of general-purpose I/O lines behind a simple register port. Software decides, for each line, whether it is a plain input, a driven output, or an interrupt source. Interrupt sources can watch for a high or low level, a rising or falling edge, or any change. Each line has a latched status bit and a per-line enable. One combined interrupt output is raised while any enabled line has its status bit set.

Pad inputs pass through a two-flop synchroniser before any use. Edge sensing compares the synchronised sample with the one taken a cycle earlier. Status bits are cleared by writing ones to a clear register. Line enables are set through one register and removed through another, so a single line can be enabled or disabled with one write. A line that the bank is driving reads back its driven value from the input-data register.

Top module: `gpio_irq_bank`

## Requirements
- R1: After synchronous reset every register holds 0. Every line is then an undriven input with no status and no enable, `irq_out` is low, and reads of every offset return 0.
- R2: Byte offsets are decoded on `bus_addr` when `bus_valid` is high. 0x00 is line mode (1 = interrupt input), 0x04 is direction (1 = output), 0x08 is output data, 0x0C is input data (read only), 0x10 is status (read only), 0x14 is status clear, 0x18 is the enable readback and disable port, 0x1C is the enable port, 0x20 is polarity, 0x24 is edge select and 0x4C is dual-edge select. Bit n of each register belongs to line n.
- R3: `pad_oe[n]` is 1 exactly when direction bit n is 1 and mode bit n is 0. `pad_out` always equals the output-data register.
- R4: A read of offset 0x0C returns the output-data bit for lines where `pad_oe` is 1, and the synchronised pad value for the other lines. A pad change shows up in this read after two rising clock edges.
- R5: Level sensing (edge-select bit 0) sets status while the pad is high (polarity 0) or low (polarity 1). While that level is present a clear has no effect. After the level goes away the status bit stays set until it is cleared.
- R6: Single-edge sensing (edge-select 1, dual-edge 0) sets status on a rising pad transition when polarity is 0 and on a falling transition when polarity is 1. Status appears on the third rising edge after the pad changes.
- R7: With edge-select 1 and dual-edge 1, both rising and falling transitions set status, whatever the polarity bit holds.
- R8: A line whose mode bit is 0 never sets its status bit, whatever its pad does.
- R9: Writing 1 to bit n at offset 0x14 clears status bit n. Data bits of 0 leave status unchanged. Writes to offset 0x10 have no effect.
- R10: When a status bit is set and cleared in the same cycle, the set takes effect.
- R11: A write to 0x1C ORs its data into the enable register. A write to 0x18 clears every enable bit whose data bit is 0 and leaves the others unchanged. Offset 0x18 reads back the enables.
- R12: `irq_out` is high exactly when some line has both its status bit and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from the offset during a read |
| pad_in | input | LINES | Asynchronous pad input values |
| pad_out | output | LINES | Values driven onto the pads |
| pad_oe | output | LINES | Per-line output enable |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Two functions of the status bit can land on the same clock edge: a detected event setting it, and a software clear removing it. The bench lines up a rising pad transition so that the write to the clear register takes effect on the same edge that the edge detector fires. It then expects the status bit to read 1. The same conflict is also provoked in level mode, by clearing while the level is still present, and the status must again stay set. Both cases are judged against control cases where the clear lands with no event pending and does remove the bit.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned REG_AW = 8;

    // Register byte offsets; software depends on these values.
    typedef enum logic [REG_AW-1:0] {
        OFS_MODE  = 8'h00,
        OFS_DIR   = 8'h04,
        OFS_DOUT  = 8'h08,
        OFS_DIN   = 8'h0C,
        OFS_STAT  = 8'h10,
        OFS_CLR   = 8'h14,
        OFS_MSK   = 8'h18,
        OFS_UNMSK = 8'h1C,
        OFS_POL   = 8'h20,
        OFS_EDGE  = 8'h24,
        OFS_BOTH  = 8'h4C
    } reg_ofs_e;

    // Per-line sensing configuration.
    typedef struct packed {
        logic irq_mode;   // line is an interrupt source
        logic low_act;    // active low level / falling edge
        logic edge_sel;   // 1 = edge, 0 = level
        logic dual_edge;  // any transition when edge_sel
    } sense_cfg_t;

    // Returns 1 when the line reports an event this cycle.
    function automatic logic sense_hit(sense_cfg_t c, logic cur, logic prv);
        logic rise;
        logic fall;
        rise = cur & ~prv;
        fall = ~cur & prv;
        if (!c.irq_mode)
            return 1'b0;
        if (!c.edge_sel)
            return cur ^ c.low_act;
        if (c.dual_edge)
            return rise | fall;
        return c.low_act ? fall : rise;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < int'(STAGES); s++)
                stg[s] <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < int'(STAGES); s++)
                stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_line_sense.sv
module gpio_line_sense
    import gpio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sense_cfg_t cfg,
    input  logic       smp,
    input  logic       clr,
    output logic       stat
);

    logic prv_q;
    logic hit;

    assign hit = sense_hit(cfg, smp, prv_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prv_q <= 1'b0;
            stat  <= 1'b0;
        end else begin
            prv_q <= smp;
            if (hit)
                stat <= 1'b1;      // set has priority over clear
            else if (clr)
                stat <= 1'b0;
        end
    end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned LINES = 32,
    parameter int unsigned DW    = 32,
    parameter int unsigned AW    = REG_AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [LINES-1:0] status,
    input  logic [LINES-1:0] din_smp,
    output logic [LINES-1:0] mode_q,
    output logic [LINES-1:0] dir_q,
    output logic [LINES-1:0] dout_q,
    output logic [LINES-1:0] pol_q,
    output logic [LINES-1:0] edge_q,
    output logic [LINES-1:0] both_q,
    output logic [LINES-1:0] mask_q,
    output logic [LINES-1:0] clr_pulse,
    output logic [LINES-1:0] oe
);

    logic             wr;
    logic             rd;
    logic [LINES-1:0] wd;
    logic [LINES-1:0] rsel;

    function automatic logic at(reg_ofs_e o);
        return bus_addr == AW'(o);
    endfunction

    assign wr = bus_valid & bus_write;
    assign rd = bus_valid & ~bus_write;
    assign wd = LINES'(bus_wdata);
    assign oe = dir_q & ~mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            dir_q  <= '0;
            dout_q <= '0;
            pol_q  <= '0;
            edge_q <= '0;
            both_q <= '0;
            mask_q <= '0;
        end else if (wr) begin
            if (at(OFS_MODE))  mode_q <= wd;
            if (at(OFS_DIR))   dir_q  <= wd;
            if (at(OFS_DOUT))  dout_q <= wd;
            if (at(OFS_POL))   pol_q  <= wd;
            if (at(OFS_EDGE))  edge_q <= wd;
            if (at(OFS_BOTH))  both_q <= wd;
            if (at(OFS_MSK))   mask_q <= mask_q & wd;
            if (at(OFS_UNMSK)) mask_q <= mask_q | wd;
        end
    end

    assign clr_pulse = (wr && at(OFS_CLR)) ? wd : '0;

    always_comb begin
        rsel = '0;
        if (at(OFS_MODE))  rsel = mode_q;
        if (at(OFS_DIR))   rsel = dir_q;
        if (at(OFS_DOUT))  rsel = dout_q;
        if (at(OFS_DIN))   rsel = (dout_q & oe) | (din_smp & ~oe);
        if (at(OFS_STAT))  rsel = status;
        if (at(OFS_MSK))   rsel = mask_q;
        if (at(OFS_POL))   rsel = pol_q;
        if (at(OFS_EDGE))  rsel = edge_q;
        if (at(OFS_BOTH))  rsel = both_q;
    end

    assign bus_rdata = rd ? DW'(rsel) : '0;

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int unsigned LINES       = 32,
    parameter int unsigned DW          = 32,
    parameter int unsigned AW          = REG_AW,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [LINES-1:0] pad_in,
    output logic [LINES-1:0] pad_out,
    output logic [LINES-1:0] pad_oe,
    output logic             irq_out
);

    logic [LINES-1:0] smp;
    logic [LINES-1:0] status_q;
    logic [LINES-1:0] mode_q;
    logic [LINES-1:0] dir_q;
    logic [LINES-1:0] dout_q;
    logic [LINES-1:0] pol_q;
    logic [LINES-1:0] edge_q;
    logic [LINES-1:0] both_q;
    logic [LINES-1:0] mask_q;
    logic [LINES-1:0] clr_pulse;
    logic [LINES-1:0] oe;

    gpio_sync #(
        .W      (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (smp)
    );

    gpio_regs #(
        .LINES (LINES),
        .DW    (DW),
        .AW    (AW)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .status    (status_q),
        .din_smp   (smp),
        .mode_q    (mode_q),
        .dir_q     (dir_q),
        .dout_q    (dout_q),
        .pol_q     (pol_q),
        .edge_q    (edge_q),
        .both_q    (both_q),
        .mask_q    (mask_q),
        .clr_pulse (clr_pulse),
        .oe        (oe)
    );

    for (genvar i = 0; i < int'(LINES); i++) begin : g_line
        sense_cfg_t cfg;
        assign cfg = '{irq_mode: mode_q[i], low_act: pol_q[i],
                       edge_sel: edge_q[i], dual_edge: both_q[i]};
        gpio_line_sense u_sense (
            .clk  (clk),
            .rst  (rst),
            .cfg  (cfg),
            .smp  (smp[i]),
            .clr  (clr_pulse[i]),
            .stat (status_q[i])
        );
    end

    assign pad_out = dout_q;
    assign pad_oe  = oe;
    assign irq_out = |(status_q & mask_q);

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
    parameter int unsigned LINES = 32,
    parameter int unsigned DW    = 32,
    parameter int unsigned AW    = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_valid,
    input logic             bus_write,
    input logic [AW-1:0]    bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic [LINES-1:0] pad_oe,
    input logic             irq_out,
    input logic [LINES-1:0] mode_q,
    input logic [LINES-1:0] mask_q,
    input logic [LINES-1:0] status_q
);

    logic wr_msk;
    logic wr_unmsk;
    assign wr_msk   = bus_valid && bus_write && bus_addr == AW'(gpio_irq_pkg::OFS_MSK);
    assign wr_unmsk = bus_valid && bus_write && bus_addr == AW'(gpio_irq_pkg::OFS_UNMSK);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (mode_q == '0 && mask_q == '0 && status_q == '0 && !irq_out));

    // R3
    irq_line_undriven_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & mode_q) == '0);

    // R8
    gp_line_no_status_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(mode_q)) == '0));

    // R11
    disable_port_no_set_chk: assert property (@(posedge clk) disable iff (rst)
        wr_msk |=> ((mask_q & ~$past(mask_q)) == '0));

    // R11
    enable_port_no_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wr_unmsk |=> (($past(mask_q) & ~mask_q) == '0 &&
                      ($past(bus_wdata[LINES-1:0]) & ~mask_q) == '0));

    // R12
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq_out);

    // R12
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (rst)
        (status_q == '0) |-> !irq_out);

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
    .LINES (LINES),
    .DW    (DW),
    .AW    (AW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_oe    (pad_oe),
    .irq_out   (irq_out),
    .mode_q    (mode_q),
    .mask_q    (mask_q),
    .status_q  (status_q)
);

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;

    localparam int unsigned LINES = 32;
    localparam int unsigned DW    = 32;
    localparam int unsigned AW    = 8;

    localparam logic [7:0] A_MODE = 8'h00, A_DIR = 8'h04, A_DOUT = 8'h08,
                           A_DIN = 8'h0C, A_STAT = 8'h10, A_CLR = 8'h14,
                           A_MSK = 8'h18, A_UNMSK = 8'h1C, A_POL = 8'h20,
                           A_EDGE = 8'h24, A_BOTH = 8'h4C;

    typedef struct packed {
        logic [31:0] pol;
        logic [31:0] edg;
        logic [31:0] both;
        logic [31:0] a;
        logic [31:0] b;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h00000000, 32'hFFFFFFFF, 32'h00000000, 32'h0000FFFF, 32'h00FF00FF},
        '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h0000FFFF, 32'h00FF00FF},
        '{32'h0F0F0F0F, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0000FFFF, 32'h00FF00FF},
        '{32'h0F0F0F0F, 32'h00000000, 32'hFFFFFFFF, 32'h33333333, 32'h0000FFFF},
        '{32'h3C3C3C3C, 32'hAAAA5555, 32'h0000FF00, 32'h12345678, 32'h87654321},
        '{32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_valid = 1'b0;
    logic             bus_write = 1'b0;
    logic [AW-1:0]    bus_addr = '0;
    logic [DW-1:0]    bus_wdata = '0;
    logic [DW-1:0]    bus_rdata;
    logic [LINES-1:0] pad_in = '0;
    logic [LINES-1:0] pad_out;
    logic [LINES-1:0] pad_oe;
    logic             irq_out;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;   // 50 MHz

    gpio_irq_bank #(.LINES(LINES), .DW(DW), .AW(AW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq_out   (irq_out)
    );

    function automatic logic [31:0] model(vec_t v);
        logic [31:0] rise, fall, ev, lvl;
        rise = ~v.a & v.b;
        fall = v.a & ~v.b;
        ev   = (v.both & (v.a ^ v.b)) | (~v.both & ((v.pol & fall) | (~v.pol & rise)));
        lvl  = (v.a ^ v.pol) | (v.b ^ v.pol);
        return (v.edg & ev) | (~v.edg & lvl);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    // Read in the current low phase, sampled well away from the edges.
    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        peek(a, d);
    endtask

    task automatic set_pad(input logic [31:0] v);
        @(negedge clk);
        pad_in = v;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        foreach (VECS[k]) begin end
        begin
            logic [7:0] offs [11] = '{A_MODE, A_DIR, A_DOUT, A_DIN, A_STAT, A_CLR,
                                      A_MSK, A_UNMSK, A_POL, A_EDGE, A_BOTH};
            foreach (offs[k]) begin
                rd(offs[k], r);
                check("R1 reset readback", r, 32'h0);
            end
        end
        check("R1 reset pad_oe", pad_oe, 32'h0);
        check("R1 reset irq_out", {31'h0, irq_out}, 32'h0);

        // R3 / R4: output drive and input readback
        wr(A_DIR, 32'h0000FFFF);
        wr(A_DOUT, 32'h12345678);
        set_pad(32'hFFFF0000);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R3 pad_oe", pad_oe, 32'h0000FFFF);
        check("R3 pad_out", pad_out, 32'h12345678);
        rd(A_DIN, r);
        check("R4 din mixed", r, 32'hFFFF5678);
        wr(A_MODE, 32'h000000FF);
        @(negedge clk);
        check("R3 mode blocks oe", pad_oe, 32'h0000FF00);
        rd(A_DIN, r);
        check("R4 din after mode", r, 32'hFFFF5600);
        // R4: two-edge latency
        @(negedge clk) pad_in = 32'h0;
        @(posedge clk);
        @(negedge clk) peek(A_DIN, r);
        check("R4 din one edge", r, 32'hFFFF5600);
        @(posedge clk);
        @(negedge clk) peek(A_DIN, r);
        check("R4 din two edges", r, 32'h00005600);
        wr(A_MODE, 32'h0);
        wr(A_DIR, 32'h0);
        wr(A_DOUT, 32'h0);
        wr(A_CLR, 32'hFFFFFFFF);

        // R8: general lines never latch
        wr(A_EDGE, 32'hFFFFFFFF);
        wr(A_BOTH, 32'hFFFFFFFF);
        set_pad(32'hFFFFFFFF);
        repeat (4) @(posedge clk);
        set_pad(32'h0);
        repeat (4) @(posedge clk);
        rd(A_STAT, r);
        check("R8 no status in general mode", r, 32'h0);

        // R5 / R6 / R7: vector table
        for (int k = 0; k < NV; k++) begin
            wr(A_POL, VECS[k].pol);
            wr(A_EDGE, VECS[k].edg);
            wr(A_BOTH, VECS[k].both);
            wr(A_MODE, 32'hFFFFFFFF);
            set_pad(VECS[k].a);
            repeat (4) @(posedge clk);
            wr(A_CLR, 32'hFFFFFFFF);
            set_pad(VECS[k].b);
            repeat (4) @(posedge clk);
            rd(A_STAT, r);
            check($sformatf("R5 R6 R7 vector %0d", k), r, model(VECS[k]));
        end
        wr(A_MODE, 32'h0);
        set_pad(32'h0);
        repeat (4) @(posedge clk);
        wr(A_CLR, 32'hFFFFFFFF);
        wr(A_BOTH, 32'h0);
        wr(A_POL, 32'h0);

        // R5: level held, clear blocked while active
        wr(A_EDGE, 32'h0);
        wr(A_MODE, 32'h1);
        set_pad(32'h1);
        repeat (4) @(posedge clk);
        rd(A_STAT, r);
        check("R5 level sets", r, 32'h1);
        wr(A_CLR, 32'h1);
        rd(A_STAT, r);
        check("R5 clear while active", r, 32'h1);
        set_pad(32'h0);
        repeat (4) @(posedge clk);
        rd(A_STAT, r);
        check("R5 stays after level gone", r, 32'h1);
        wr(A_CLR, 32'h1);
        rd(A_STAT, r);
        check("R5 clear after level gone", r, 32'h0);

        // R9: zero bits and status offset writes ignored
        wr(A_EDGE, 32'h3);
        wr(A_MODE, 32'h3);
        set_pad(32'h3);
        repeat (4) @(posedge clk);
        rd(A_STAT, r);
        check("R6 two rising edges", r, 32'h3);
        wr(A_CLR, 32'h1);
        rd(A_STAT, r);
        check("R9 partial clear", r, 32'h2);
        wr(A_STAT, 32'hFFFFFFFF);
        rd(A_STAT, r);
        check("R9 status write ignored", r, 32'h2);
        wr(A_CLR, 32'h2);
        rd(A_STAT, r);
        check("R9 clear second", r, 32'h0);
        set_pad(32'h0);
        repeat (4) @(posedge clk);
        rd(A_STAT, r);
        check("R6 falling ignored", r, 32'h0);

        // R10: set and clear on the same edge
        @(negedge clk) pad_in = 32'h1;
        @(posedge clk);
        @(posedge clk);
        wr(A_CLR, 32'h1);
        @(negedge clk) peek(A_STAT, r);
        check("R10 set wins", r, 32'h1);

        // R11 / R12: enables and combined interrupt
        rd(A_MSK, r);
        check("R11 enables empty", r, 32'h0);
        check("R12 irq low without enable", {31'h0, irq_out}, 32'h0);
        wr(A_UNMSK, 32'h5);
        rd(A_MSK, r);
        check("R11 enable port", r, 32'h5);
        check("R12 irq high", {31'h0, irq_out}, 32'h1);
        wr(A_UNMSK, 32'h2);
        rd(A_MSK, r);
        check("R11 enable port ors", r, 32'h7);
        wr(A_MSK, 32'hFFFFFFFE);
        rd(A_MSK, r);
        check("R11 disable line 0", r, 32'h6);
        check("R12 irq low after disable", {31'h0, irq_out}, 32'h0);
        wr(A_MSK, 32'hFFFFFFFF);
        rd(A_MSK, r);
        check("R11 ones keep enables", r, 32'h6);
        wr(A_UNMSK, 32'h1);
        @(negedge clk);
        check("R12 irq back high", {31'h0, irq_out}, 32'h1);
        wr(A_CLR, 32'h1);
        @(negedge clk);
        check("R12 irq low after clear", {31'h0, irq_out}, 32'h0);

        // R2: offsets are distinct registers
        wr(A_POL, 32'hA5A5A5A5);
        wr(A_BOTH, 32'h5A5A5A5A);
        rd(A_POL, r);
        check("R2 polarity offset", r, 32'hA5A5A5A5);
        rd(A_BOTH, r);
        check("R2 dual-edge offset", r, 32'h5A5A5A5A);
        rd(8'h28, r);
        check("R2 unmapped offset", r, 32'h0);

        finish_run();
    end

endmodule